// File: doc/BRIEF.md
# Supply-Guarded Byte-Wide Static Memory

This block is a clocked, synthesizable model of a 2048-byte static memory with active-low select, write strobe and output-enable controls, guarded by a supply supervisor. An external comparator supplies a digital power-good level. While that level is low, or during the lockout that follows its return, every control and address input is ignored, nothing is written, the data outputs float and stored bytes are kept.

A write window is the overlap of select and write strobe, both low. The address and data sampled during the window's last open cycle are committed on the clock edge where either strobe is first seen high. Reads are combinational from the array, and the bus is driven only when select and output enable are low and the write strobe is high. The recovery lockout is a clock-count parameter. Analog detection, battery switch-over and nanosecond pin timing are represented by the power-good input and by cycle counts.

No data stream with flow control crosses this block's edge. All pins are plain level controls sampled on the clock, so there is no valid/ready pair and no back-pressure.

Top module: `nvram_guard`

## Requirements
- R1: Reset loads the lockout. `locked` is 1 and `bus_drive` is 0 from reset until power-good has been sampled high on RECOVER_CYCLES edges after reset release.
- R2: When unlocked and power is good, with `sel_n`=0, `wstb_n`=1 and `oen_n`=0, `bus_drive` is 1 and `rd_byte` equals the byte stored at `addr` in the same cycle.
- R3: `bus_drive` is 0 whenever `sel_n`=1 or `oen_n`=1, and `rd_byte` is 0 whenever `bus_drive` is 0.
- R4: The byte sampled with its address on the last edge where both `sel_n` and `wstb_n` were low is stored on the next edge where either strobe is sampled high. This holds whichever strobe falls first or rises first, and a later data value in a multi-cycle window replaces an earlier one.
- R5: `wstb_n`=0 forces `bus_drive` to 0 in the same cycle, even when the bus was being driven.
- R6: In any cycle with `pwr_good`=0, `bus_drive` is 0, strobes have no effect and no byte is written. `locked` is 1 after the first edge that samples `pwr_good` low.
- R7: Every edge that samples `pwr_good` low reloads the lockout. `locked` falls only after RECOVER_CYCLES consecutive edges sampling `pwr_good` high, so a one-cycle dropout restarts the full count.
- R8: A write window that is open when power fails is discarded. The addressed byte keeps its old value even if the strobes later rise.
- R9: After a lockout ends, no write window can open until both `sel_n` and `wstb_n` have been sampled high. Strobes held low across the release write nothing.
- R10: Stored bytes survive any number of power-fail and recovery sequences unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply in tolerance, from an external comparator |
| sel_n | input | 1 | Active-low chip select |
| wstb_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output enable |
| addr | input | 11 | Byte address |
| wr_byte | input | 8 | Write data |
| rd_byte | output | 8 | Read data, 0 when not driven |
| bus_drive | output | 1 | High when the data bus would be driven |
| locked | output | 1 | Write protection in force |

## Verification
A wrong lockout count shows up on `locked` on the exact edge it should fall, and on `bus_drive` in the same cycle. A stray or lost window state does not show at once. It appears as a wrong byte the next time that address is read, so every write is followed by a readback. The bench compares every cycle against a behavioural model. A bad arming or abort decision therefore shows on the first later read of the affected address, normally within a few cycles.

// File: rtl/nvg_pkg.sv
package nvg_pkg;
  localparam int ADDR_W_DEF  = 11;
  localparam int DATA_W_DEF  = 8;
  // 40 ms at a 100 MHz clock
  localparam int RECOVER_DEF = 4_000_000;

  // arming phase of the write path
  typedef enum logic [1:0] {
    PH_LOCKED = 2'd0,
    PH_WAIT   = 2'd1,
    PH_READY  = 2'd2
  } arm_phase_e;
endpackage

// File: rtl/nvg_supervisor.sv
module nvg_supervisor #(
  parameter int RECOVER_CYCLES = nvg_pkg::RECOVER_DEF,
  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic locked_o,
  output logic blocked_o
);
  logic [CNT_W-1:0] hold_cnt;

  // reload on every bad sample, count down while the supply stays good
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= CNT_W'(RECOVER_CYCLES);
    else if (!pwr_good)
      hold_cnt <= CNT_W'(RECOVER_CYCLES);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - CNT_W'(1);
  end

  assign locked_o  = (hold_cnt != '0);
  // a low supply level blocks access in the very cycle it appears
  assign blocked_o = locked_o | ~pwr_good;
endmodule

// File: rtl/nvg_write_ctrl.sv
module nvg_write_ctrl #(
  parameter int ADDR_W = nvg_pkg::ADDR_W_DEF,
  parameter int DATA_W = nvg_pkg::DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_byte,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import nvg_pkg::*;

  arm_phase_e        phase_q;
  logic              win_q;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              both_high, both_low, win_open;

  assign both_high = sel_n & wstb_n;
  assign both_low  = ~sel_n & ~wstb_n;
  assign win_open  = ~blocked & (phase_q == PH_READY) & both_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= PH_LOCKED;
    else if (blocked)
      phase_q <= PH_LOCKED;
    else begin
      case (phase_q)
        PH_LOCKED: phase_q <= both_high ? PH_READY : PH_WAIT;
        PH_WAIT:   if (both_high) phase_q <= PH_READY;
        default:   phase_q <= PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_q <= 1'b0;
    else
      win_q <= win_open;
  end

  // last address and data seen while the window is open
  always_ff @(posedge clk) begin
    if (win_open) begin
      hold_addr <= addr;
      hold_data <= wr_byte;
    end
  end

  assign commit      = win_q & ~blocked & ~both_low;
  assign commit_addr = hold_addr;
  assign commit_data = hold_data;
endmodule

// File: rtl/nvg_array.sv
module nvg_array #(
  parameter int ADDR_W = nvg_pkg::ADDR_W_DEF,
  parameter int DATA_W = nvg_pkg::DATA_W_DEF,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvram_guard.sv
module nvram_guard #(
  parameter int ADDR_W         = nvg_pkg::ADDR_W_DEF,
  parameter int DATA_W         = nvg_pkg::DATA_W_DEF,
  parameter int RECOVER_CYCLES = nvg_pkg::RECOVER_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              wstb_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] rd_byte,
  output logic              bus_drive,
  output logic              locked
);
  logic              blocked;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] cell_q;

  nvg_supervisor #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_sup (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .locked_o (locked),
    .blocked_o(blocked)
  );

  nvg_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .blocked    (blocked),
    .sel_n      (sel_n),
    .wstb_n     (wstb_n),
    .addr       (addr),
    .wr_byte    (wr_byte),
    .commit     (commit),
    .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  nvg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .wr_en  (commit),
    .wr_addr(commit_addr),
    .wr_data(commit_data),
    .rd_addr(addr),
    .rd_data(cell_q)
  );

  assign bus_drive = ~blocked & ~sel_n & wstb_n & ~oen_n;
  assign rd_byte   = bus_drive ? cell_q : '0;
endmodule

// File: rtl/nvram_guard_chk.sv
module nvram_guard_chk #(
  parameter int DATA_W = nvg_pkg::DATA_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              sel_n,
  input logic              wstb_n,
  input logic              oen_n,
  input logic [DATA_W-1:0] rd_byte,
  input logic              bus_drive,
  input logic              locked
);
  // R3
  deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || oen_n) |-> !bus_drive);
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (rd_byte == '0));
  // R5
  strobe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb_n |-> !bus_drive);
  // R6
  fail_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> !bus_drive);
  // R6
  fail_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> locked);
  // R7
  release_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pwr_good));
  // R1
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !bus_drive);
endmodule

bind nvram_guard nvram_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .sel_n    (sel_n),
  .wstb_n   (wstb_n),
  .oen_n    (oen_n),
  .rd_byte  (rd_byte),
  .bus_drive(bus_drive),
  .locked   (locked)
);

// File: tb/test_nvram_guard.sv
module test_nvram_guard;
  localparam int REC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b1;
  logic       sel_n = 1'b1, wstb_n = 1'b1, oen_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       bus_drive, locked;

  int vectors = 0;
  int misses = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  int ref_mem [2048];
  int ref_wait;
  bit ref_armed, ref_win;
  int ref_wa, ref_wd;

  always #5 clk = ~clk;

  nvram_guard #(.RECOVER_CYCLES(REC)) i_nvram_guard (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n),
    .wstb_n(wstb_n), .oen_n(oen_n), .addr(addr), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .bus_drive(bus_drive), .locked(locked)
  );

  task automatic compare();
    bit stop, exp_drive;
    int exp_rd;
    stop = (ref_wait > 0) || !pwr_good;
    exp_drive = !stop && !sel_n && wstb_n && !oen_n;
    exp_rd = exp_drive ? ref_mem[addr] : 0;
    vectors++;
    if (locked !== (ref_wait > 0)) begin
      misses++;
      $display("FAIL %s locked=%b expected %b", req, locked, ref_wait > 0);
    end
    if (bus_drive !== exp_drive) begin
      misses++;
      $display("FAIL %s bus_drive=%b expected %b", req, bus_drive, exp_drive);
    end
    if (exp_rd >= 0 && rd_byte !== 8'(exp_rd)) begin
      misses++;
      $display("FAIL %s rd_byte=%h expected %h", req, rd_byte, exp_rd);
    end
  endtask

  task automatic advance_model();
    bit stop, hi, lo;
    stop = (ref_wait > 0) || !pwr_good;
    hi = sel_n && wstb_n;
    lo = !sel_n && !wstb_n;
    if (!stop && ref_win && !lo) ref_mem[ref_wa] = ref_wd;
    ref_win = !stop && ref_armed && lo;
    if (ref_win) begin
      ref_wa = int'(addr);
      ref_wd = int'(wr_byte);
    end
    ref_armed = stop ? 1'b0 : (ref_armed || hi);
    if (!pwr_good) ref_wait = REC;
    else if (ref_wait > 0) ref_wait--;
  endtask

  task automatic step(input bit pg, input bit s, input bit w, input bit o,
                      input int a, input int d);
    pwr_good = pg; sel_n = s; wstb_n = w; oen_n = o;
    addr = 11'(a); wr_byte = 8'(d);
    #1;
    compare();
    @(posedge clk);
    advance_model();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 1, 0, 0);
  endtask

  task automatic rd(input int a);
    step(1, 0, 1, 0, a, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) ref_mem[i] = -1;
    ref_wait = REC; ref_armed = 0; ref_win = 0; ref_wa = 0; ref_wd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: lockout after reset, read attempts stay floating
    req = "R1";
    for (int i = 0; i < REC + 3; i++) step(1, 0, 1, 0, 7, 0);
    idle(2);
    // R4: select-first, strobe rises first
    req = "R4";
    step(1, 0, 1, 1, 0, 0); step(1, 0, 0, 1, 0, 8'hA5);
    step(1, 0, 1, 1, 0, 0); idle(1);
    // R4: strobe-first, select rises first
    step(1, 1, 0, 1, 2047, 0); step(1, 0, 0, 1, 2047, 8'h3C);
    step(1, 1, 0, 1, 2047, 0); idle(1);
    // R4: long window, last data wins
    step(1, 0, 0, 1, 100, 8'h11); step(1, 0, 0, 1, 100, 8'h22);
    step(1, 0, 0, 1, 100, 8'h33); idle(2);
    // R2: reads
    req = "R2";
    rd(0); rd(2047); rd(100); rd(0);
    // R3: deselect or output disable
    req = "R3";
    step(1, 1, 1, 0, 0, 0); step(1, 0, 1, 1, 100, 0); idle(1);
    // R5: strobe falls during a driven read, then writes 5A
    req = "R5";
    rd(0); step(1, 0, 0, 0, 0, 8'h5A); step(1, 0, 1, 0, 0, 0); rd(0); idle(1);
    // R6: power fail, strobes ignored
    req = "R6";
    step(0, 0, 1, 0, 100, 0); step(0, 0, 0, 1, 100, 8'hFF);
    step(0, 1, 1, 1, 100, 0); step(0, 0, 0, 1, 100, 8'hEE);
    // R7: recovery and a dropout restart
    req = "R7";
    idle(10); step(0, 1, 1, 1, 0, 0); idle(REC + 2);
    req = "R6";
    rd(100);
    // R8: window open when power fails is dropped
    req = "R8";
    idle(1);
    step(1, 0, 0, 1, 2047, 8'h00); step(0, 0, 0, 1, 2047, 8'h00);
    step(0, 1, 1, 1, 2047, 0); idle(REC + 1); rd(2047);
    // R9: strobes held low across the release
    req = "R9";
    step(0, 0, 0, 1, 0, 8'h77);
    for (int i = 0; i < REC + 3; i++) step(1, 0, 0, 1, 0, 8'h77);
    idle(1); rd(0);
    // R10: contents after several fail cycles
    req = "R10";
    for (int k = 0; k < 3; k++) begin
      step(0, 1, 1, 1, 0, 0); idle(REC + 1);
    end
    rd(0); rd(2047); rd(100);
    idle(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule